// File: doc/BRIEF.md
# Interrupt Winner Selection and Preemption Decision

This block watches three fixed-rank system exceptions and a bank of configurable interrupt lines. Every clock it picks the single most urgent pending request and decides whether that request may interrupt the handler that is running now. Each interrupt line has a small priority register of its own, written through a simple strobe port. A grouping input divides each priority value into an upper group part and a lower sub-ordering part. The group part alone decides preemption. Selection uses the full value.

The three outputs are the winner's index, a flag that marks the index as meaningful, and a preempt request. All three are registered and appear one clock after the inputs that produced them. They are plain status pins. There is no handshake and no back-pressure, so a consumer samples them whenever it needs to. Priority writes, the pending inputs and the active-handler inputs are also plain control pins.

Top module: `irq_preempt_arb`

## Requirements
- R1: A synchronous active-high reset clears all three outputs to 0 and returns every interrupt priority register to 0.
- R2: Among pending interrupt lines, a numerically smaller priority value wins.
- R3: When pending interrupt lines share the lowest priority value, the line with the lowest number wins. This applies at any value.
- R4: The index is encoded as follows: reset exception is 0, hard fault is 1, NMI is 2, and interrupt line k is 3+k. Any pending system exception beats every interrupt line. Among system exceptions the rank is reset, then hard fault, then NMI.
- R5: With an active handler and an interrupt winner, preempt is 1 only if the winner's group value is strictly below the active priority's group value. Equal group values never preempt.
- R6: The grouping input sets how many low priority bits form the sub-ordering part, from 0 to 3. Values above 3 act as 3. The group value is the priority shifted right by that count.
- R7: When no handler is active, any valid winner raises preempt.
- R8: A system exception winner always raises preempt.
- R9: With nothing pending, the valid flag, the index and preempt are all 0.
- R10: Outputs follow the inputs one clock later. A priority write takes effect in the register at the edge where it is strobed.
- R11: Winner selection compares group, then sub-ordering, then line number. This order does not depend on the grouping input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_wr_en | input | 1 | Strobe to write one priority register |
| prio_wr_sel | input | 3 | Interrupt line whose priority is written |
| prio_wr_val | input | 3 | Priority value written |
| grp_sel | input | 3 | Count of sub-ordering bits (clamped to 3) |
| sys_pend | input | 3 | Pending system exceptions: bit0 reset, bit1 hard fault, bit2 NMI |
| irq_pend | input | 8 | Pending interrupt lines, bit k for line k |
| act_valid | input | 1 | A handler is currently running |
| act_prio | input | 3 | Priority of the running handler |
| win_valid | output | 1 | A winner exists |
| win_idx | output | 4 | Winner index (encoding in R4) |
| preempt | output | 1 | Winner may interrupt the running handler |

## Verification
The bench targets several corner cases, each tied to a likely design error:
- Ties at a nonzero priority: a design that breaks ties toward the highest line number, or only at value 0, returns the wrong index.
- Equal-group pairs at every grouping setting, including clamped values above 3: a design that compares full priorities, or uses a non-strict compare, raises preempt where it must stay low.
- Sub-ordering inside one group: a design that ranks by group alone falls back to the lowest line number.
- Reset in mid-run: a design that leaves the priority registers alone after reset keeps the old winner.
- System exceptions against an active handler at priority 0: a design that compares system exceptions like ordinary lines fails to preempt.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PW    = 3;
  localparam int SYS_N = 3;

  // number of sub-ordering bits after clamping to the priority width
  function automatic int unsigned sub_bits(input int unsigned g, input int unsigned pw);
    return (g > pw) ? pw : g;
  endfunction
endpackage

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
  parameter int N  = 8,
  parameter int PW = 3,
  localparam int SW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_sel,
  input  logic [PW-1:0]   wr_val,
  output logic [N*PW-1:0] prio_flat
);
  for (genvar k = 0; k < N; k++) begin : g_reg
    logic [PW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_en && wr_sel == SW'(k)) q <= wr_val;
    end
    assign prio_flat[k*PW +: PW] = q;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> prio_flat == '0);
endmodule

// File: rtl/irq_min_select.sv
module irq_min_select #(
  parameter int N     = 8,
  parameter int PW    = 3,
  parameter int SYS_N = 3,
  localparam int IDXW = $clog2(N + SYS_N),
  localparam int LVLW = $clog2(SYS_N + (1 << PW))
) (
  input  logic [SYS_N-1:0] sys_pend,
  input  logic [N-1:0]     irq_pend,
  input  logic [N*PW-1:0]  prio_flat,
  output logic             any,
  output logic [IDXW-1:0]  idx,
  output logic             is_sys,
  output logic [PW-1:0]    win_prio
);
  logic [LVLW-1:0] best;
  logic [LVLW-1:0] lvl;

  always_comb begin
    any      = 1'b0;
    idx      = '0;
    is_sys   = 1'b0;
    win_prio = '0;
    best     = '1;
    lvl      = '0;
    // system exceptions first, ascending: strict compare keeps lowest index
    for (int i = 0; i < SYS_N; i++) begin
      lvl = LVLW'(i);
      if (sys_pend[i] && (!any || lvl < best)) begin
        any = 1'b1; best = lvl; idx = IDXW'(i); is_sys = 1'b1; win_prio = '0;
      end
    end
    for (int k = 0; k < N; k++) begin
      lvl = LVLW'(SYS_N) + LVLW'(prio_flat[k*PW +: PW]);
      if (irq_pend[k] && (!any || lvl < best)) begin
        any = 1'b1; best = lvl; idx = IDXW'(SYS_N + k); is_sys = 1'b0;
        win_prio = prio_flat[k*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_preempt_cmp.sv
module irq_preempt_cmp #(
  parameter int PW = 3,
  parameter int GW = 3,
  localparam int SUBW = $clog2(PW + 1)
) (
  input  logic [GW-1:0] grp_sel,
  input  logic          win_any,
  input  logic          win_is_sys,
  input  logic [PW-1:0] win_prio,
  input  logic          act_valid,
  input  logic [PW-1:0] act_prio,
  output logic          preempt
);
  import irq_arb_pkg::*;
  logic [SUBW-1:0] sub_n;
  logic [PW-1:0]   win_grp, act_grp;

  always_comb begin
    sub_n   = SUBW'(sub_bits(int'(grp_sel), PW));
    win_grp = win_prio >> sub_n;
    act_grp = act_prio >> sub_n;
    preempt = win_any && (win_is_sys || !act_valid || (win_grp < act_grp));
  end
endmodule

// File: rtl/irq_preempt_arb.sv
module irq_preempt_arb #(
  parameter int N     = 8,
  parameter int GW    = 3,
  localparam int PW   = irq_arb_pkg::PW,
  localparam int SYSN = irq_arb_pkg::SYS_N,
  localparam int SW   = $clog2(N),
  localparam int IDXW = $clog2(N + SYSN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prio_wr_en,
  input  logic [SW-1:0]   prio_wr_sel,
  input  logic [PW-1:0]   prio_wr_val,
  input  logic [GW-1:0]   grp_sel,
  input  logic [SYSN-1:0] sys_pend,
  input  logic [N-1:0]    irq_pend,
  input  logic            act_valid,
  input  logic [PW-1:0]   act_prio,
  output logic            win_valid,
  output logic [IDXW-1:0] win_idx,
  output logic            preempt
);
  logic [N*PW-1:0] prio_flat;
  logic            sel_any, sel_sys, pre_c;
  logic [IDXW-1:0] sel_idx;
  logic [PW-1:0]   sel_prio;

  irq_prio_bank #(.N(N), .PW(PW)) u_bank (
    .clk(clk), .rst(rst), .wr_en(prio_wr_en), .wr_sel(prio_wr_sel),
    .wr_val(prio_wr_val), .prio_flat(prio_flat)
  );

  irq_min_select #(.N(N), .PW(PW), .SYS_N(SYSN)) u_sel (
    .sys_pend(sys_pend), .irq_pend(irq_pend), .prio_flat(prio_flat),
    .any(sel_any), .idx(sel_idx), .is_sys(sel_sys), .win_prio(sel_prio)
  );

  irq_preempt_cmp #(.PW(PW), .GW(GW)) u_cmp (
    .grp_sel(grp_sel), .win_any(sel_any), .win_is_sys(sel_sys),
    .win_prio(sel_prio), .act_valid(act_valid), .act_prio(act_prio),
    .preempt(pre_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_idx   <= '0;
      preempt   <= 1'b0;
    end else begin
      win_valid <= sel_any;
      win_idx   <= sel_idx;
      preempt   <= pre_c;
    end
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_pend == '0 && irq_pend == '0) |=> (!win_valid && !preempt && win_idx == '0));
  // R8
  sys_preempts_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_pend != '0) |=> (win_valid && preempt && win_idx < IDXW'(SYSN)));
  // R4
  reset_exc_first_chk: assert property (@(posedge clk) disable iff (rst)
    sys_pend[0] |=> (win_idx == '0));
  // R7
  idle_cpu_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_valid && (sys_pend != '0 || irq_pend != '0)) |=> preempt);
  // R1
  out_reset_chk: assert property (@(posedge clk) rst |=> (!win_valid && !preempt && win_idx == '0));
endmodule

// File: tb/sim_irq_preempt_arb.sv
module sim_irq_preempt_arb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prio_wr_en = 1'b0;
  logic [2:0] prio_wr_sel = '0;
  logic [2:0] prio_wr_val = '0;
  logic [2:0] grp_sel = '0;
  logic [2:0] sys_pend = '0;
  logic [7:0] irq_pend = '0;
  logic       act_valid = 1'b0;
  logic [2:0] act_prio = '0;
  logic       win_valid, preempt;
  logic [3:0] win_idx;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  irq_preempt_arb u0 (
    .clk(clk), .rst(rst), .prio_wr_en(prio_wr_en), .prio_wr_sel(prio_wr_sel),
    .prio_wr_val(prio_wr_val), .grp_sel(grp_sel), .sys_pend(sys_pend),
    .irq_pend(irq_pend), .act_valid(act_valid), .act_prio(act_prio),
    .win_valid(win_valid), .win_idx(win_idx), .preempt(preempt)
  );

  typedef struct packed {
    logic [23:0] pr;   // octal digit k = priority of line k
    logic [2:0]  grp;
    logic        av;
    logic [2:0]  ap;
    logic [2:0]  sys;
    logic [7:0]  irq;
    logic        ev;
    logic [3:0]  ei;
    logic        ep;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{24'o00000000, 3'd0, 1'b0, 3'd0, 3'b000, 8'b00000000, 1'b0, 4'd0, 1'b0}, // R9 idle
    '{24'o00000000, 3'd0, 1'b0, 3'd0, 3'b000, 8'b10100000, 1'b1, 4'd8, 1'b1}, // R3 R7
    '{24'o01234567, 3'd0, 1'b1, 3'd4, 3'b000, 8'b00001111, 1'b1, 4'd6, 1'b0}, // R5 equal
    '{24'o01234567, 3'd0, 1'b1, 3'd4, 3'b000, 8'b00011111, 1'b1, 4'd7, 1'b1}, // R2 R5
    '{24'o01234567, 3'd1, 1'b1, 3'd2, 3'b000, 8'b00011111, 1'b1, 4'd7, 1'b0}, // R6 grp1
    '{24'o01234567, 3'd3, 1'b1, 3'd7, 3'b000, 8'b00011111, 1'b1, 4'd7, 1'b0}, // R6 grp3
    '{24'o01234567, 3'd6, 1'b1, 3'd7, 3'b000, 8'b00011111, 1'b1, 4'd7, 1'b0}, // R6 clamp
    '{24'o01234567, 3'd2, 1'b1, 3'd7, 3'b000, 8'b00011111, 1'b1, 4'd7, 1'b1}, // R6 grp2
    '{24'o01234567, 3'd0, 1'b1, 3'd0, 3'b100, 8'b11111111, 1'b1, 4'd2, 1'b1}, // R4 R8 NMI
    '{24'o01234567, 3'd0, 1'b1, 3'd0, 3'b110, 8'b11111111, 1'b1, 4'd1, 1'b1}, // R4 fault
    '{24'o01234567, 3'd0, 1'b1, 3'd0, 3'b111, 8'b11111111, 1'b1, 4'd0, 1'b1}, // R4 reset
    '{24'o00000023, 3'd2, 1'b0, 3'd0, 3'b000, 8'b00000011, 1'b1, 4'd4, 1'b1}, // R11 sub
    '{24'o00000023, 3'd2, 1'b1, 3'd3, 3'b000, 8'b00000001, 1'b1, 4'd3, 1'b0}, // R11 R5
    '{24'o55555555, 3'd0, 1'b1, 3'd5, 3'b000, 8'b11000000, 1'b1, 4'd9, 1'b0}  // R3 nonzero
  };

  function automatic string vtag(input int v);
    case (v)
      0: return "R9"; 1: return "R3/R7"; 2: return "R5"; 3: return "R2/R5";
      4, 5, 6, 7: return "R6"; 8, 9, 10: return "R4/R8";
      11, 12: return "R11"; default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input logic v, input logic [3:0] i, input logic p);
    n_chk++;
    if (win_valid !== v || win_idx !== i || preempt !== p) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b idx=%0d preempt=%0b, expected valid=%0b idx=%0d preempt=%0b",
               tag, win_valid, win_idx, preempt, v, i, p);
    end
  endtask

  task automatic write_prios(input logic [23:0] pr);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      prio_wr_en = 1'b1; prio_wr_sel = 3'(k); prio_wr_val = pr[k*3 +: 3];
    end
    @(negedge clk);
    prio_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got running, expected done");
        finish_run();
      end
    end
  end

  initial begin
    // R1: outputs and priority registers cleared by reset
    irq_pend = 8'b10000001; act_valid = 1'b1; act_prio = 3'd0;
    repeat (2) @(negedge clk);
    check("R1 outputs in reset", 1'b0, 4'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 default priorities", 1'b1, 4'd3, 1'b0);

    foreach (TBL[v]) begin
      write_prios(TBL[v].pr);
      grp_sel = TBL[v].grp; act_valid = TBL[v].av; act_prio = TBL[v].ap;
      sys_pend = TBL[v].sys; irq_pend = TBL[v].irq;
      @(negedge clk);
      check(vtag(v), TBL[v].ev, TBL[v].ei, TBL[v].ep);
    end

    // R10: one-cycle latency; value visible only after the edge
    sys_pend = '0; irq_pend = '0;
    @(negedge clk);
    irq_pend = 8'b00000100; act_valid = 1'b0;
    #2 check("R10 before edge", 1'b0, 4'd0, 1'b0);
    @(negedge clk);
    check("R10 after edge", 1'b1, 4'd5, 1'b1);

    // R10: write and pend together; priority used at the following edge
    write_prios(24'o00000000);
    irq_pend = 8'b00000011;
    @(negedge clk);
    prio_wr_en = 1'b1; prio_wr_sel = 3'd0; prio_wr_val = 3'd6;
    @(negedge clk);
    prio_wr_en = 1'b0;
    @(negedge clk);
    check("R10 write visible", 1'b1, 4'd4, 1'b1);

    // R1: mid-run reset restores priority 0 (line1 was 5, line2 was 1)
    write_prios(24'o00000150);
    irq_pend = 8'b00000110;
    @(negedge clk);
    check("R2 before reset", 1'b1, 4'd5, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 priorities after reset", 1'b1, 4'd4, 1'b1);

    finish_run();
  end
endmodule